// File: doc/BRIEF.md
# Dependency Latency Interlock Scoreboard

This block sits at the issue point of an in-order pipeline and decides, each cycle, whether the instruction presented on its request port may start. Every request names an operation class, one destination register and two source registers. For every architectural register the scoreboard remembers how many cycles have elapsed since its last producer issued and which class that producer was. From these it derives the wait owed to each pending dependence and raises `stall` while any of them is still open.

The wait depends on the kind of dependence. Reading a register whose producer is in flight waits the producer's latency. A pair-specific override may replace that latency, taken from a small bypass table whose entries may be gated by per-cycle guard flags. Writing a register that an in-flight producer also writes waits only the difference between the two default latencies, clamped at zero. Writing a register that an earlier instruction merely reads costs nothing. Contention for functional units or result ports is handled elsewhere.

The stall is combinational from the request and the stored state. The stored state changes only when a request actually issues.

Top module: `dep_interlock`

## Requirements
- R1: The class codes are 0 simple integer, 1 multiply, 2 divide and 3 float, with default latencies of 2, 4, 9 and 3 cycles. A reader of a register first presented in the cycle after its producer issued stalls for latency minus one cycles, then issues.
- R2: A float producer feeding a simple, multiply or divide reader uses an effective latency of 4. A float-to-float pair keeps 3.
- R3: The bypass table has four entries, indexed 0 to 3. Guard bit k belongs to entry k. Entry 0 is unguarded: float to simple/multiply/divide, latency 4. Entry 1 is guarded: multiply to simple, latency 1. Entry 2 is guarded: multiply to simple, latency 2. Entry 3 is unguarded: multiply to simple, latency 3. The lowest-indexed guarded match with its guard bit set wins. Otherwise the lowest unguarded match applies. Otherwise the producer's default latency applies. Guard bits of unguarded entries have no effect.
- R4: When the destination is still being written by an in-flight producer, the wait is the producer's default latency minus the new instruction's default latency. A negative difference counts as zero.
- R5: Writing a register that an in-flight instruction only reads never stalls.
- R6: Register 0 is never tracked: reading or writing it never stalls, and issuing a write to it records nothing.
- R7: `stall` is low whenever `req_valid` is low. The tracking state updates only on a cycle with `req_valid` high and `stall` low. A withdrawn or stalled request leaves no trace.
- R8: Synchronous active-high reset marks every register ready, so no request stalls after reset.
- R9: The per-register elapsed counter saturates at its maximum value. A register untouched for many cycles stays ready and never wraps back to busy.
- R10: Both source operands are checked, and the stall lasts until the slowest open dependence resolves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An instruction is presented this cycle |
| req_class | input | 2 | Operation class code |
| req_dst | input | 4 | Destination register index |
| req_src_a | input | 4 | First source register index |
| req_src_b | input | 4 | Second source register index |
| bypass_guard | input | 4 | Guard flag per bypass entry, valid this cycle |
| stall | output | 1 | Request must wait; no issue this cycle |

## Verification
The bench measures the exact number of stall cycles for each producer/reader class pair, so an off-by-one in the counter start value shows up as one stall too many or too few. It sweeps the guard bits for the multiply-to-simple pair. A design that scanned guarded entries in the wrong order, or honoured guard bits on unguarded entries, would return a wrong wait. Output dependences in both latency orders catch a missing clamp, which would stall forever or wrap to a huge wait. Other tests target a stalled request that is later withdrawn, register 0, and a long idle gap. A design that updated on stall, tracked register 0, or let the counter wrap would stall a reader that should pass.

// File: rtl/dli_pkg.sv
`timescale 1ns/1ps
package dli_pkg;
    localparam int NCLS  = 4;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_DIV = 2'd2,
        CLS_FLT = 2'd3
    } op_class_e;
endpackage

// File: rtl/dli_lat_select.sv
`timescale 1ns/1ps
// Resolves the effective producer latency for one producer/consumer pair.
module dli_lat_select #(
    parameter int                      NBYP        = 4,
    parameter int                      AGE_W       = 4,
    parameter logic [4*AGE_W-1:0]      DEF_LAT     = 16'h3942,
    parameter logic [NBYP*4-1:0]       BYP_PROD    = 16'h2228,
    parameter logic [NBYP*4-1:0]       BYP_CONS    = 16'h1117,
    parameter logic [NBYP*AGE_W-1:0]   BYP_LAT     = 16'h3214,
    parameter logic [NBYP-1:0]         BYP_GUARDED = 4'b0110
) (
    input  logic [dli_pkg::CLS_W-1:0] prod_cls,
    input  logic [dli_pkg::CLS_W-1:0] cons_cls,
    input  logic [NBYP-1:0]           guard,
    output logic [AGE_W-1:0]          eff_lat
);
    logic             g_hit, u_hit, pair_ok;
    logic [AGE_W-1:0] g_lat, u_lat;

    always_comb begin
        g_hit   = 1'b0;
        u_hit   = 1'b0;
        g_lat   = '0;
        u_lat   = '0;
        pair_ok = 1'b0;
        for (int e = 0; e < NBYP; e++) begin
            pair_ok = BYP_PROD[e*4 + int'(prod_cls)] && BYP_CONS[e*4 + int'(cons_cls)];
            if (pair_ok && BYP_GUARDED[e] && guard[e] && !g_hit) begin
                g_hit = 1'b1;
                g_lat = BYP_LAT[e*AGE_W +: AGE_W];
            end
            if (pair_ok && !BYP_GUARDED[e] && !u_hit) begin
                u_hit = 1'b1;
                u_lat = BYP_LAT[e*AGE_W +: AGE_W];
            end
        end
        if (g_hit)      eff_lat = g_lat;
        else if (u_hit) eff_lat = u_lat;
        else            eff_lat = DEF_LAT[int'(prod_cls)*AGE_W +: AGE_W];
    end
endmodule

// File: rtl/dli_track.sv
`timescale 1ns/1ps
// Per-register elapsed-cycle counters and producer classes.
module dli_track #(
    parameter int NREG  = 16,
    parameter int AGE_W = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [dli_pkg::CLS_W-1:0]         wr_cls,
    output logic [NREG-1:0][AGE_W-1:0]        age_o,
    output logic [NREG-1:0][dli_pkg::CLS_W-1:0] cls_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    typedef struct packed {
        logic [NREG-1:0][AGE_W-1:0]          age;
        logic [NREG-1:0][dli_pkg::CLS_W-1:0] cls;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (st_q.age[i] != AGE_MAX) st_d.age[i] = st_q.age[i] + AGE_ONE;
            if (i != 0 && wr_en && wr_idx == IDX_W'(i)) begin
                st_d.age[i] = AGE_ONE;
                st_d.cls[i] = wr_cls;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.age <= {NREG*AGE_W{1'b1}};
            st_q.cls <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign age_o = st_q.age;
    assign cls_o = st_q.cls;

    // R7: an issued write restarts the destination's counter
    assert_write_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0) |=> (st_q.age[$past(wr_idx)] == AGE_ONE));

    for (genvar g = 1; g < NREG; g++) begin : g_sat
        // R9: a ready register stays ready without a write
        assert_age_saturate_R9: assert property (@(posedge clk) disable iff (rst)
            (st_q.age[g] == AGE_MAX && !(wr_en && wr_idx == IDX_W'(g)))
            |=> (st_q.age[g] == AGE_MAX));
    end
endmodule

// File: rtl/dep_interlock.sv
`timescale 1ns/1ps
module dep_interlock #(
    parameter int                      NREG        = 16,
    parameter int                      AGE_W       = 4,
    parameter int                      NBYP        = 4,
    parameter logic [4*AGE_W-1:0]      DEF_LAT     = 16'h3942,
    parameter logic [NBYP*4-1:0]       BYP_PROD    = 16'h2228,
    parameter logic [NBYP*4-1:0]       BYP_CONS    = 16'h1117,
    parameter logic [NBYP*AGE_W-1:0]   BYP_LAT     = 16'h3214,
    parameter logic [NBYP-1:0]         BYP_GUARDED = 4'b0110,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [dli_pkg::CLS_W-1:0] req_class,
    input  logic [IDX_W-1:0]          req_dst,
    input  logic [IDX_W-1:0]          req_src_a,
    input  logic [IDX_W-1:0]          req_src_b,
    input  logic [NBYP-1:0]           bypass_guard,
    output logic                      stall
);
    localparam int NSRC = 2;

    logic [NREG-1:0][AGE_W-1:0]          age;
    logic [NREG-1:0][dli_pkg::CLS_W-1:0] pcls;
    logic [NSRC-1:0][IDX_W-1:0]          src;
    logic [NSRC-1:0][AGE_W-1:0]          need;
    logic [NSRC-1:0]                     raw_hit;
    logic [AGE_W-1:0]                    lat_prod, lat_cons, waw_need;
    logic                                waw_hit, issue;

    assign src[0] = req_src_a;
    assign src[1] = req_src_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        dli_lat_select #(
            .NBYP(NBYP), .AGE_W(AGE_W), .DEF_LAT(DEF_LAT),
            .BYP_PROD(BYP_PROD), .BYP_CONS(BYP_CONS),
            .BYP_LAT(BYP_LAT), .BYP_GUARDED(BYP_GUARDED)
        ) u_sel (
            .prod_cls (pcls[src[s]]),
            .cons_cls (req_class),
            .guard    (bypass_guard),
            .eff_lat  (need[s])
        );
        assign raw_hit[s] = (src[s] != '0) && (age[src[s]] < need[s]);
    end

    always_comb begin
        lat_prod = DEF_LAT[int'(pcls[req_dst])*AGE_W +: AGE_W];
        lat_cons = DEF_LAT[int'(req_class)*AGE_W +: AGE_W];
        waw_need = (lat_prod > lat_cons) ? (lat_prod - lat_cons) : '0;
        waw_hit  = (req_dst != '0) && (age[req_dst] < waw_need);
    end

    assign stall = req_valid && ((|raw_hit) || waw_hit);
    assign issue = req_valid && !stall;

    dli_track #(.NREG(NREG), .AGE_W(AGE_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (issue),
        .wr_idx (req_dst),
        .wr_cls (req_class),
        .age_o  (age),
        .cls_o  (pcls)
    );

    // R7: no request, no stall
    assert_idle_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !stall);

    // R8: first cycle after reset is free of stalls
    assert_reset_ready_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall);

    // R6: an instruction touching only register 0 always issues
    assert_r0_untracked_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dst == '0 && req_src_a == '0 && req_src_b == '0) |-> !stall);
endmodule

// File: tb/sim_dep_interlock.sv
`timescale 1ns/1ps
module sim_dep_interlock;
    import dli_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_class = 2'd0;
    logic [3:0] req_dst = 4'd0, req_src_a = 4'd0, req_src_b = 4'd0;
    logic [3:0] bypass_guard = 4'd0;
    logic       stall;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dep_interlock u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .req_dst(req_dst), .req_src_a(req_src_a), .req_src_b(req_src_b),
        .bypass_guard(bypass_guard), .stall(stall)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [3:0] d, a, b, g);
        req_valid = 1'b1; req_class = c; req_dst = d;
        req_src_a = a; req_src_b = b; bypass_guard = g;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; bypass_guard = 4'd0;
    endtask

    // issue a producer that is known to be hazard free
    task automatic issue(input logic [1:0] c, input logic [3:0] d, a, b);
        @(negedge clk);
        drive(c, d, a, b, 4'd0);
        @(posedge clk);
    endtask

    // present a request and count stall cycles until it issues
    task automatic measure(input logic [1:0] c, input logic [3:0] d, a, b, g, output int n);
        @(negedge clk);
        drive(c, d, a, b, g);
        #1;
        n = 0;
        while (stall && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        idle();
    endtask

    task automatic settle();
        idle();
        repeat (18) @(posedge clk);
    endtask

    task automatic t_reset();
        int n;
        measure(CLS_DIV, 4'd3, 4'd3, 4'd4, 4'd0, n);
        chk("R8 no stall after reset", n, 0);
        settle();
    endtask

    task automatic t_true_dep();
        int n;
        issue(CLS_INT, 4'd1, 4'd0, 4'd0);
        measure(CLS_INT, 4'd2, 4'd1, 4'd0, 4'd0, n);
        chk("R1 int->int", n, 1);
        settle();
        issue(CLS_MUL, 4'd1, 4'd0, 4'd0);
        measure(CLS_MUL, 4'd2, 4'd1, 4'd0, 4'd0, n);
        chk("R1 mul->mul", n, 3);
        settle();
        issue(CLS_DIV, 4'd1, 4'd0, 4'd0);
        measure(CLS_DIV, 4'd2, 4'd0, 4'd1, 4'd0, n);
        chk("R1 div->div", n, 8);
        settle();
        issue(CLS_FLT, 4'd1, 4'd0, 4'd0);
        measure(CLS_FLT, 4'd2, 4'd1, 4'd0, 4'd0, n);
        chk("R2 flt->flt keeps 3", n, 2);
        settle();
    endtask

    task automatic t_float_bypass();
        int n;
        issue(CLS_FLT, 4'd3, 4'd0, 4'd0);
        measure(CLS_INT, 4'd4, 4'd3, 4'd0, 4'd0, n);
        chk("R2 flt->int", n, 3);
        settle();
        issue(CLS_FLT, 4'd3, 4'd0, 4'd0);
        measure(CLS_MUL, 4'd4, 4'd3, 4'd0, 4'd0, n);
        chk("R2 flt->mul", n, 3);
        settle();
        issue(CLS_FLT, 4'd3, 4'd0, 4'd0);
        measure(CLS_DIV, 4'd4, 4'd0, 4'd3, 4'd0, n);
        chk("R2 flt->div", n, 3);
        settle();
    endtask

    task automatic t_guards();
        int n;
        logic [3:0] gv [5] = '{4'b0000, 4'b0010, 4'b0100, 4'b0110, 4'b1001};
        int         ex [5] = '{2, 0, 1, 0, 2};
        for (int k = 0; k < 5; k++) begin
            issue(CLS_MUL, 4'd5, 4'd0, 4'd0);
            measure(CLS_INT, 4'd6, 4'd5, 4'd0, gv[k], n);
            chk($sformatf("R3 mul->int guard=%b", gv[k]), n, ex[k]);
            settle();
        end
        issue(CLS_MUL, 4'd5, 4'd0, 4'd0);
        measure(CLS_MUL, 4'd6, 4'd5, 4'd0, 4'b0010, n);
        chk("R3 guard ignored for unmatched pair", n, 3);
        settle();
    endtask

    task automatic t_output_dep();
        int n;
        issue(CLS_DIV, 4'd7, 4'd0, 4'd0);
        measure(CLS_INT, 4'd7, 4'd0, 4'd0, 4'd0, n);
        chk("R4 div then int write", n, 6);
        settle();
        issue(CLS_INT, 4'd7, 4'd0, 4'd0);
        measure(CLS_DIV, 4'd7, 4'd0, 4'd0, 4'd0, n);
        chk("R4 int then div write clamps", n, 0);
        settle();
        issue(CLS_MUL, 4'd7, 4'd0, 4'd0);
        measure(CLS_INT, 4'd7, 4'd0, 4'd0, 4'd0, n);
        chk("R4 mul then int write", n, 1);
        settle();
    endtask

    task automatic t_anti_dep();
        int n;
        issue(CLS_DIV, 4'd9, 4'd8, 4'd0);
        measure(CLS_INT, 4'd8, 4'd0, 4'd0, 4'd0, n);
        chk("R5 write after read", n, 0);
        settle();
    endtask

    task automatic t_reg0();
        int n;
        issue(CLS_DIV, 4'd0, 4'd0, 4'd0);
        measure(CLS_INT, 4'd10, 4'd0, 4'd0, 4'd0, n);
        chk("R6 read r0 after write", n, 0);
        issue(CLS_DIV, 4'd0, 4'd0, 4'd0);
        measure(CLS_INT, 4'd0, 4'd0, 4'd0, 4'd0, n);
        chk("R6 write r0 after write", n, 0);
        settle();
    endtask

    task automatic t_no_update();
        int n;
        @(negedge clk);
        drive(CLS_DIV, 4'd11, 4'd0, 4'd0, 4'd0);
        req_valid = 1'b0;
        #1;
        chk("R7 stall low when not valid", int'(stall), 0);
        @(posedge clk);
        measure(CLS_INT, 4'd12, 4'd11, 4'd0, 4'd0, n);
        chk("R7 withdrawn request not recorded", n, 0);
        settle();
        issue(CLS_DIV, 4'd13, 4'd0, 4'd0);
        @(negedge clk);
        drive(CLS_DIV, 4'd14, 4'd13, 4'd0, 4'd0);
        #1;
        chk("R7 stalled request stalls", int'(stall), 1);
        @(negedge clk);
        idle();
        measure(CLS_INT, 4'd1, 4'd14, 4'd0, 4'd0, n);
        chk("R7 stalled request not recorded", n, 0);
        settle();
    endtask

    task automatic t_saturate();
        int n;
        issue(CLS_DIV, 4'd15, 4'd0, 4'd0);
        idle();
        repeat (22) @(posedge clk);
        measure(CLS_DIV, 4'd2, 4'd15, 4'd0, 4'd0, n);
        chk("R9 long idle stays ready", n, 0);
        settle();
    endtask

    task automatic t_two_sources();
        int n;
        issue(CLS_MUL, 4'd14, 4'd0, 4'd0);
        issue(CLS_INT, 4'd15, 4'd0, 4'd0);
        measure(CLS_INT, 4'd1, 4'd15, 4'd14, 4'd0, n);
        chk("R10 slowest of two sources", n, 1);
        settle();
        issue(CLS_DIV, 4'd6, 4'd0, 4'd0);
        measure(CLS_INT, 4'd1, 4'd0, 4'd6, 4'd0, n);
        chk("R10 second source alone", n, 8);
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_true_dep();
        t_float_bypass();
        t_guards();
        t_output_dep();
        t_anti_dep();
        t_reg0();
        t_no_update();
        t_saturate();
        t_two_sources();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule